// File: doc/BRIEF.md
# Scoreboard-Driven In-Order Multi-Issue Dispatcher

This block is the dispatch stage of a superscalar core. It sits behind an instruction queue and looks at the oldest few decoded entries every cycle. Each entry names a unit class, two source registers, and optionally a destination register. The block picks, in program order, the longest run of head entries that can leave in this cycle, binds each one to a free functional unit of the right class, and reports how many entries the queue should pop.

A one-bit-per-register scoreboard remembers which registers have a write still in flight. A bit is raised by the issue of a writer and dropped by the completion pulse that the unit returns with its destination tag. Each unit also has a busy flag. The flag is set when the unit accepts an instruction and cleared by that unit's completion pulse. The number of instructions sent in one cycle is capped by a fixed issue width that does not depend on the number of units. The default unit pool holds one branch unit, one load/store unit, three integer units and one floating-point unit. Operands are read at issue. Because issue is in order, a write-after-read conflict cannot arise. A pending destination stalls the instruction, which keeps write-after-write order.

Top module: `dispatch_top`

## Requirements
- R1: After reset no register is pending and every unit is free. With an empty window nothing issues and take_cnt is 0.
- R2: A slot does not issue while either of its source registers is marked pending in the scoreboard.
- R3: A slot with win_wr=1 does not issue while its destination register is marked pending.
- R4: Issue is in program order. Slot 0 is the oldest. The first slot that cannot issue, or that is not valid, stops every younger slot in that cycle. take_cnt equals the number of leading slots issued.
- R5: Within one cycle, a slot whose source or (when writing) destination equals the destination of an older slot issued with win_wr=1 in the same cycle does not issue.
- R6: Class codes are 0 branch, 1 load/store, 2 integer, 3 floating point. Units are numbered with branch units first, then load/store, then integer, then floating point. By default unit 0 is branch, 1 is load/store, 2 to 4 are integer and 5 is floating point. A slot goes only to a free unit of its class, to the lowest-numbered one not already taken that cycle. The unit's iss_dst, iss_sa, iss_sb and iss_wr carry the slot's fields.
- R7: At most ISSUE_W (default 4) instructions issue per cycle, even when more units are free.
- R8: Issuing a writer marks its destination pending from the next cycle. A done_vld pulse with done_wr=1 clears done_dst at that clock edge. The clear is seen from the next cycle, not in the cycle of the pulse.
- R9: A unit is busy from the cycle after it accepts an instruction until the cycle after its done_vld pulse. A busy unit is never given an instruction.
- R10: A younger slot that writes a register read by an older slot issued in the same cycle may issue in that cycle.
- R11: A slot with win_wr=0 marks no register pending, and its win_dst field blocks neither itself nor younger slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | WIN | Slot holds a decoded instruction |
| win_wr | input | WIN | Slot writes its destination register |
| win_dst | input | WIN x RW | Destination register per slot |
| win_sa | input | WIN x RW | First source register per slot |
| win_sb | input | WIN x RW | Second source register per slot |
| win_cls | input | WIN x 2 | Unit class per slot |
| take_cnt | output | CW | Number of head slots issued this cycle |
| iss_vld | output | NU | Unit receives an instruction this cycle |
| iss_wr | output | NU | Issued instruction writes a register |
| iss_dst | output | NU x RW | Destination of the issued instruction |
| iss_sa | output | NU x RW | First source of the issued instruction |
| iss_sb | output | NU x RW | Second source of the issued instruction |
| done_vld | input | NU | Unit completes its instruction this cycle |
| done_wr | input | NU | Completing instruction wrote a register |
| done_dst | input | NU x RW | Destination tag of the completing instruction |

## Verification
On every cycle the assertions check the following. No issued instruction reads or rewrites a pending register. No busy unit is handed work. The issue count stays within the width and agrees with take_cnt. Scoreboard bits and busy flags hold until the matching completion arrives. Blocking of younger slots, lowest-index unit choice, the same-cycle dependency checks, the allowed same-cycle write-after-read, the one-cycle delay before a completion frees a register, and the cap with spare units can only be shown by the bench. It replays directed and random instruction streams through a reference model with unit latencies of 1, 2, 1 and 3 cycles.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    typedef enum logic [1:0] {
        CLS_BR  = 2'd0,
        CLS_LS  = 2'd1,
        CLS_INT = 2'd2,
        CLS_FP  = 2'd3
    } ucls_e;

    // Class served by unit index u, given the unit mix (ordered BR, LS, INT, FP)
    function automatic ucls_e class_of(input int u, input int nbr, input int nls, input int nint);
        if (u < nbr)
            return CLS_BR;
        else if (u < nbr + nls)
            return CLS_LS;
        else if (u < nbr + nls + nint)
            return CLS_INT;
        else
            return CLS_FP;
    endfunction

endpackage

// File: rtl/dispatch_scoreboard.sv
module dispatch_scoreboard #(
    parameter int NREGS = 32,
    parameter int NU    = 6,
    parameter int RW    = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NREGS-1:0]       set_vec,
    input  logic [NU-1:0]          done_vld,
    input  logic [NU-1:0]          done_wr,
    input  logic [NU-1:0][RW-1:0]  done_dst,
    output logic [NREGS-1:0]       pend
);

    logic [NREGS-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int u = 0; u < NU; u++) begin
            if (done_vld[u] && done_wr[u])
                clr_vec[done_dst[u]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (pend & ~clr_vec) | set_vec;
    end

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_chk
            AST_MARK_SET: assert property (@(posedge clk) disable iff (rst)
                set_vec[r] |=> pend[r]);                                   // R8
            AST_MARK_HELD: assert property (@(posedge clk) disable iff (rst)
                (pend[r] && !clr_vec[r]) |=> pend[r]);                     // R8
            AST_MARK_CLEAR: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[r] && !set_vec[r]) |=> !pend[r]);                 // R8
        end
    endgenerate

endmodule

// File: rtl/dispatch_unit_track.sv
module dispatch_unit_track #(
    parameter int NU = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NU-1:0] iss_vld,
    input  logic [NU-1:0] done_vld,
    output logic [NU-1:0] busy
);

    always_ff @(posedge clk) begin
        if (rst)
            busy <= '0;
        else
            busy <= (busy & ~done_vld) | iss_vld;
    end

    generate
        for (genvar u = 0; u < NU; u++) begin : g_chk
            AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
                done_vld[u] |-> busy[u]);                                  // R9
            AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
                (busy[u] && !done_vld[u]) |=> busy[u]);                    // R9
            AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
                iss_vld[u] |=> busy[u]);                                   // R9
        end
    endgenerate

endmodule

// File: rtl/dispatch_select.sv
module dispatch_select
    import dispatch_pkg::*;
#(
    parameter int NREGS   = 32,
    parameter int WIN     = 6,
    parameter int ISSUE_W = 4,
    parameter int N_BR    = 1,
    parameter int N_LS    = 1,
    parameter int N_INT   = 3,
    parameter int N_FP    = 1,
    parameter int RW      = $clog2(NREGS),
    parameter int NU      = N_BR + N_LS + N_INT + N_FP,
    parameter int CW      = $clog2(WIN + 1)
) (
    input  logic [WIN-1:0]          win_vld,
    input  logic [WIN-1:0]          win_wr,
    input  logic [WIN-1:0][RW-1:0]  win_dst,
    input  logic [WIN-1:0][RW-1:0]  win_sa,
    input  logic [WIN-1:0][RW-1:0]  win_sb,
    input  logic [WIN-1:0][1:0]     win_cls,
    input  logic [NREGS-1:0]        pend,
    input  logic [NU-1:0]           busy,
    output logic [CW-1:0]           take_cnt,
    output logic [NU-1:0]           iss_vld,
    output logic [NU-1:0]           iss_wr,
    output logic [NU-1:0][RW-1:0]   iss_dst,
    output logic [NU-1:0][RW-1:0]   iss_sa,
    output logic [NU-1:0][RW-1:0]   iss_sb,
    output logic [NREGS-1:0]        set_vec
);

    // Serial walk from the oldest slot: each slot sees units and destinations claimed by older slots
    always_comb begin
        logic [NU-1:0]    avail;
        logic [NREGS-1:0] grp;
        logic             stop;
        logic             ready;
        logic             src_hit;
        logic             dst_hit;
        int               cnt;
        int               sel;

        avail    = ~busy;
        grp      = '0;
        stop     = 1'b0;
        cnt      = 0;
        iss_vld  = '0;
        iss_wr   = '0;
        iss_dst  = '0;
        iss_sa   = '0;
        iss_sb   = '0;
        set_vec  = '0;
        for (int s = 0; s < WIN; s++) begin
            sel = -1;
            for (int u = 0; u < NU; u++) begin
                if (sel < 0 && avail[u] && win_cls[s] == 2'(class_of(u, N_BR, N_LS, N_INT)))
                    sel = u;
            end
            src_hit = pend[win_sa[s]] || grp[win_sa[s]] || pend[win_sb[s]] || grp[win_sb[s]];
            dst_hit = win_wr[s] && (pend[win_dst[s]] || grp[win_dst[s]]);
            ready   = win_vld[s] && !stop && (cnt < ISSUE_W) && (sel >= 0) && !src_hit && !dst_hit;
            if (ready) begin
                for (int u = 0; u < NU; u++) begin
                    if (u == sel) begin
                        iss_vld[u] = 1'b1;
                        iss_wr[u]  = win_wr[s];
                        iss_dst[u] = win_dst[s];
                        iss_sa[u]  = win_sa[s];
                        iss_sb[u]  = win_sb[s];
                        avail[u]   = 1'b0;
                    end
                end
                cnt = cnt + 1;
                if (win_wr[s]) begin
                    grp[win_dst[s]]     = 1'b1;
                    set_vec[win_dst[s]] = 1'b1;
                end
            end else begin
                stop = 1'b1;
            end
        end
        take_cnt = CW'(cnt);
    end

endmodule

// File: rtl/dispatch_top.sv
module dispatch_top
    import dispatch_pkg::*;
#(
    parameter int NREGS   = 32,
    parameter int WIN     = 6,
    parameter int ISSUE_W = 4,
    parameter int N_BR    = 1,
    parameter int N_LS    = 1,
    parameter int N_INT   = 3,
    parameter int N_FP    = 1,
    localparam int RW     = $clog2(NREGS),
    localparam int NU     = N_BR + N_LS + N_INT + N_FP,
    localparam int CW     = $clog2(WIN + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIN-1:0]         win_vld,
    input  logic [WIN-1:0]         win_wr,
    input  logic [WIN-1:0][RW-1:0] win_dst,
    input  logic [WIN-1:0][RW-1:0] win_sa,
    input  logic [WIN-1:0][RW-1:0] win_sb,
    input  logic [WIN-1:0][1:0]    win_cls,
    output logic [CW-1:0]          take_cnt,
    output logic [NU-1:0]          iss_vld,
    output logic [NU-1:0]          iss_wr,
    output logic [NU-1:0][RW-1:0]  iss_dst,
    output logic [NU-1:0][RW-1:0]  iss_sa,
    output logic [NU-1:0][RW-1:0]  iss_sb,
    input  logic [NU-1:0]          done_vld,
    input  logic [NU-1:0]          done_wr,
    input  logic [NU-1:0][RW-1:0]  done_dst
);

    logic [NREGS-1:0] pend;
    logic [NREGS-1:0] set_vec;
    logic [NU-1:0]    busy;

    dispatch_select #(
        .NREGS(NREGS), .WIN(WIN), .ISSUE_W(ISSUE_W),
        .N_BR(N_BR), .N_LS(N_LS), .N_INT(N_INT), .N_FP(N_FP),
        .RW(RW), .NU(NU), .CW(CW)
    ) u_select (
        .win_vld(win_vld), .win_wr(win_wr), .win_dst(win_dst),
        .win_sa(win_sa), .win_sb(win_sb), .win_cls(win_cls),
        .pend(pend), .busy(busy),
        .take_cnt(take_cnt), .iss_vld(iss_vld), .iss_wr(iss_wr),
        .iss_dst(iss_dst), .iss_sa(iss_sa), .iss_sb(iss_sb),
        .set_vec(set_vec)
    );

    dispatch_scoreboard #(.NREGS(NREGS), .NU(NU), .RW(RW)) u_sb (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .done_vld(done_vld), .done_wr(done_wr), .done_dst(done_dst),
        .pend(pend)
    );

    dispatch_unit_track #(.NU(NU)) u_track (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .done_vld(done_vld), .busy(busy)
    );

    AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (rst)
        $countones(iss_vld) <= ISSUE_W);                                   // R7
    AST_TAKE_MATCH: assert property (@(posedge clk) disable iff (rst)
        int'(take_cnt) == $countones(iss_vld));                            // R4

    generate
        for (genvar u = 0; u < NU; u++) begin : g_chk
            AST_NO_RAW: assert property (@(posedge clk) disable iff (rst)
                iss_vld[u] |-> (!pend[iss_sa[u]] && !pend[iss_sb[u]]));    // R2
            AST_NO_WAW: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[u] && iss_wr[u]) |-> !pend[iss_dst[u]]);          // R3
            AST_NO_BUSY_ISSUE: assert property (@(posedge clk) disable iff (rst)
                iss_vld[u] |-> !busy[u]);                                  // R9
        end
    endgenerate

endmodule

// File: tb/dispatch_top_test.sv
`timescale 1ns/1ps
module dispatch_top_test;

    localparam int NREGS = 32;
    localparam int WIN   = 6;
    localparam int IW    = 4;
    localparam int NU    = 6;
    localparam int RW    = 5;
    localparam int CW    = 3;

    typedef struct {
        int cls;
        bit wr;
        int dst;
        int sa;
        int sb;
    } ins_t;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [WIN-1:0]         win_vld = '0;
    logic [WIN-1:0]         win_wr = '0;
    logic [WIN-1:0][RW-1:0] win_dst = '0;
    logic [WIN-1:0][RW-1:0] win_sa = '0;
    logic [WIN-1:0][RW-1:0] win_sb = '0;
    logic [WIN-1:0][1:0]    win_cls = '0;
    logic [CW-1:0]          take_cnt;
    logic [NU-1:0]          iss_vld, iss_wr;
    logic [NU-1:0][RW-1:0]  iss_dst, iss_sa, iss_sb;
    logic [NU-1:0]          done_vld = '0;
    logic [NU-1:0]          done_wr = '0;
    logic [NU-1:0][RW-1:0]  done_dst = '0;

    dispatch_top uut (
        .clk(clk), .rst(rst),
        .win_vld(win_vld), .win_wr(win_wr), .win_dst(win_dst),
        .win_sa(win_sa), .win_sb(win_sb), .win_cls(win_cls),
        .take_cnt(take_cnt), .iss_vld(iss_vld), .iss_wr(iss_wr),
        .iss_dst(iss_dst), .iss_sa(iss_sa), .iss_sb(iss_sb),
        .done_vld(done_vld), .done_wr(done_wr), .done_dst(done_dst)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // reference state
    ins_t q[$];
    bit   pend_m[NREGS];
    int   ucnt[NU];
    bit   uwr[NU];
    int   udst[NU];
    int   last_take;
    logic [NU-1:0] last_mask;

    function automatic int unit_kind(int u);
        if (u == 0) return 0;
        if (u == 1) return 1;
        if (u <= 4) return 2;
        return 3;
    endfunction

    function automatic int unit_lat(int u);
        case (unit_kind(u))
            1: return 2;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_list(int r, int lst[$]);
        foreach (lst[i]) if (lst[i] == r) return 1;
        return 0;
    endfunction

    task automatic drive_inputs();
        for (int s = 0; s < WIN; s++) begin
            if (s < q.size()) begin
                win_vld[s] = 1'b1;
                win_wr[s]  = q[s].wr;
                win_dst[s] = RW'(q[s].dst);
                win_sa[s]  = RW'(q[s].sa);
                win_sb[s]  = RW'(q[s].sb);
                win_cls[s] = 2'(q[s].cls);
            end else begin
                win_vld[s] = 1'b0;
                win_wr[s]  = 1'b0;
                win_dst[s] = '0;
                win_sa[s]  = '0;
                win_sb[s]  = '0;
                win_cls[s] = '0;
            end
        end
        for (int u = 0; u < NU; u++) begin
            done_vld[u] = (ucnt[u] == 1);
            done_wr[u]  = (ucnt[u] == 1) && uwr[u];
            done_dst[u] = RW'(udst[u]);
        end
    endtask

    // one cycle: drive, predict, compare, advance the reference
    task automatic step();
        int   took;
        int   slot_of[NU];
        bit   claimed[NU];
        int   wrote[$];
        @(negedge clk);
        drive_inputs();
        #1;
        took = 0;
        for (int u = 0; u < NU; u++) begin
            slot_of[u] = -1;
            claimed[u] = (ucnt[u] != 0);
        end
        for (int s = 0; s < WIN; s++) begin
            int pick;
            if (s >= q.size() || took == IW) break;
            if (pend_m[q[s].sa] || in_list(q[s].sa, wrote)) break;
            if (pend_m[q[s].sb] || in_list(q[s].sb, wrote)) break;
            if (q[s].wr && (pend_m[q[s].dst] || in_list(q[s].dst, wrote))) break;
            pick = -1;
            for (int u = 0; u < NU; u++) begin
                if (pick < 0 && !claimed[u] && unit_kind(u) == q[s].cls) pick = u;
            end
            if (pick < 0) break;
            claimed[pick] = 1;
            slot_of[pick] = s;
            if (q[s].wr) wrote.push_back(q[s].dst);
            took++;
        end
        last_take = int'(take_cnt);
        last_mask = iss_vld;
        check(int'(take_cnt) == took, "R4 take count", int'(take_cnt), took);
        for (int u = 0; u < NU; u++) begin
            check(iss_vld[u] == (slot_of[u] >= 0), "R6 unit select", int'(iss_vld[u]), int'(slot_of[u] >= 0));
            if (slot_of[u] >= 0 && iss_vld[u]) begin
                ins_t e;
                e = q[slot_of[u]];
                check(int'(iss_dst[u]) == e.dst && int'(iss_sa[u]) == e.sa &&
                      int'(iss_sb[u]) == e.sb && iss_wr[u] == e.wr,
                      "R6 issued fields", int'(iss_dst[u]), e.dst);
            end
        end
        // advance reference state as of the coming edge
        for (int u = 0; u < NU; u++) begin
            if (ucnt[u] == 1 && uwr[u]) pend_m[udst[u]] = 0;
            if (ucnt[u] > 0) ucnt[u]--;
        end
        for (int u = 0; u < NU; u++) begin
            if (slot_of[u] >= 0) begin
                ins_t e;
                e = q[slot_of[u]];
                ucnt[u] = unit_lat(u);
                uwr[u]  = e.wr;
                udst[u] = e.dst;
                if (e.wr) pend_m[e.dst] = 1;
            end
        end
        for (int i = 0; i < took; i++) void'(q.pop_front());
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) begin
            bit idle;
            idle = (q.size() == 0);
            for (int u = 0; u < NU; u++) if (ucnt[u] != 0) idle = 0;
            if (idle) break;
            step();
        end
    endtask

    task automatic push(int cls, bit wr, int dst, int sa, int sb);
        ins_t e;
        e.cls = cls; e.wr = wr; e.dst = dst; e.sa = sa; e.sb = sb;
        q.push_back(e);
    endtask

    initial begin
        for (int r = 0; r < NREGS; r++) pend_m[r] = 0;
        for (int u = 0; u < NU; u++) begin ucnt[u] = 0; uwr[u] = 0; udst[u] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty window after reset
        step();
        check(last_take == 0 && last_mask == '0, "R1 reset idle", last_take, 0);

        // R7 / R6: six independent instructions, four leave, lowest units taken
        push(0, 0, 20, 24, 25);
        push(1, 1, 2, 26, 27);
        push(2, 1, 3, 28, 29);
        push(2, 1, 4, 30, 31);
        push(2, 1, 5, 24, 26);
        push(3, 1, 6, 27, 28);
        step();
        check(last_take == 4, "R7 issue cap", last_take, 4);
        check(last_mask == 6'b001111, "R6 lowest units", int'(last_mask), 6'b001111);
        step();
        check(last_take == 2 && last_mask == 6'b110000, "R6 spare integer unit", int'(last_mask), 6'b110000);
        drain();

        // R5: same-cycle read of an older destination
        push(2, 1, 3, 1, 2);
        push(2, 1, 4, 3, 1);
        step();
        check(last_take == 1, "R5 group source hit", last_take, 1);
        drain();

        // R5: same-cycle rewrite of an older destination
        push(2, 1, 11, 1, 2);
        push(2, 1, 11, 3, 4);
        step();
        check(last_take == 1, "R5 group dest hit", last_take, 1);
        drain();

        // R10: younger writer of an older source in the same cycle
        push(2, 1, 8, 9, 10);
        push(2, 1, 9, 1, 2);
        step();
        check(last_take == 2, "R10 same-cycle write after read", last_take, 2);
        drain();

        // R11: non-writer destination is ignored
        push(0, 0, 20, 1, 2);
        push(2, 1, 21, 20, 20);
        push(2, 1, 22, 1, 2);
        step();
        check(last_take == 3, "R11 non-writer dest", last_take, 3);
        step();
        check(last_take == 0 && last_mask == '0, "R11 nothing left", last_take, 0);
        drain();

        // R2 / R8: floating-point write, then a reader of it
        push(3, 1, 7, 1, 2);
        push(2, 1, 12, 7, 1);
        step();
        check(last_take == 1, "R5 reader waits in group", last_take, 1);
        step();
        check(last_take == 0, "R2 source pending", last_take, 0);
        step();
        check(last_take == 0, "R2 source still pending", last_take, 0);
        step();
        check(last_take == 0, "R8 no bypass on done", last_take, 0);
        step();
        check(last_take == 1 && last_mask == 6'b000100, "R8 cleared next cycle", int'(last_mask), 6'b000100);
        drain();

        // R3: load/store write, then a second writer of the same register
        push(1, 1, 6, 1, 2);
        push(2, 1, 6, 3, 4);
        step();
        check(last_take == 1, "R5 second writer in group", last_take, 1);
        step();
        check(last_take == 0, "R3 dest pending", last_take, 0);
        step();
        check(last_take == 0, "R3 dest pending at done", last_take, 0);
        step();
        check(last_take == 1, "R3 dest free", last_take, 1);
        drain();

        // R4 / R9: four integer ops and a floating-point op behind them
        push(2, 1, 1, 10, 11);
        push(2, 1, 2, 10, 11);
        push(2, 1, 3, 10, 11);
        push(2, 1, 4, 10, 11);
        push(3, 1, 5, 10, 11);
        step();
        check(last_take == 3 && last_mask == 6'b011100, "R4 order blocks younger", int'(last_mask), 6'b011100);
        step();
        check(last_take == 0, "R9 units busy during done", last_take, 0);
        step();
        check(last_take == 2 && last_mask == 6'b100100, "R9 units freed", int'(last_mask), 6'b100100);
        drain();

        // random streams over a small register set
        for (int c = 0; c < 600; c++) begin
            while (q.size() < WIN) begin
                int k;
                k = $urandom_range(0, 3);
                push(k, (k == 0) ? 1'b0 : 1'($urandom_range(0, 1)),
                     $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            end
            step();
        end
        drain();

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule